// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm

This block keeps a free-running 48-bit tick count that advances once for each pulse of a 32.768 kHz time-base enable. Because it counts raw ticks, whole seconds sit in bits 47..15 and the low 15 bits are the fraction of a second. A host reaches the count and a 48-bit alarm compare value through a 16-bit synchronous register bus. The bus has a byte address, a write strobe, write data and combinational read data. Each 48-bit quantity is split into three halfwords.

When the counter steps onto the compare value, the elapsed-time flag in a shared interrupt status register is set. Three neighbouring timer sources can set the other flags of that register through event inputs. The host clears flags by writing ones. A mask register gates each flag onto the single interrupt line.

Reads do not latch the other halfwords, so a carry can ripple between two accesses. Software reads the three halfwords twice and repeats until both passes agree. Calendar conversion is left to software.

Top module: `elapsed_alarm_timer`

## Requirements
- R1: Out of reset, the counter, compare, status and mask registers read zero and `irq_o` is low.
- R2: The counter increases by exactly one after each clock edge at which `tick_i` is high, and holds its value otherwise.
- R3: Byte offsets 0x00, 0x02 and 0x04 read counter bits 15:0, 31:16 and 47:32. A carry out of one halfword propagates into the next halfword on the same tick.
- R4: A write to a counter halfword replaces only those 16 bits at the next edge. If `tick_i` is high in the same cycle, the increment is lost for the written halfword, while the other halfwords still take the incremented value, carry included.
- R5: Byte offsets 0x08, 0x0A and 0x0C hold compare bits 15:0, 31:16 and 47:32 and read back what was written. Offsets 0x06 and 0x0E are reserved: they read zero, and writing them changes no register.
- R6: One cycle after the counter changes to a value equal to the compare value, status bit 0 (elapsed time) is set. The flag is not set again while the counter stays unchanged.
- R7: The status register at byte offset 0x3E is write-one-to-clear over bits 3..0. Zero bits leave their flags alone. A set event in the same cycle wins over a clear.
- R8: A high `evt_i[0]`, `evt_i[1]` or `evt_i[2]` sets status bit 1, bit 2 or bit 3 respectively at the next edge.
- R9: `irq_o` is high exactly when some status bit is set and the matching bit of the mask register is also set. The mask register sits at byte offset 0x3C, bits 3..0.
- R10: A seconds value S is held as S[0] in low-halfword bit 15, S[16:1] in the middle halfword and S[31:17] in the high halfword. A tick from fraction 0x7FFF advances S by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz time-base enable, one clock wide |
| evt_i | input | 3 | Set pulses for status bits 1, 2 and 3 |
| addr_i | input | 6 | Byte address; bit 0 is ignored |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Masked OR of the status flags |

## Verification
The bench drives carries from the low halfword into the middle halfword and from the middle halfword into the high halfword. It also lands a halfword write on the same edge as a tick; a design that let either the write or the tick win across the whole word would show the wrong middle or low halfword. The alarm is checked at the tick that reaches the compare value, and again while the counter rests there. A design that compares every cycle would set the flag again after the host cleared it. The bench also checks that writes of zero bits leave flags alone, that a set racing a clear survives, that the mask gates the interrupt line, and that the reserved offsets stay inert. A flaw in any of these shows up as a wrong readback or a wrong interrupt level.

// File: rtl/etm_pkg.sv
`timescale 1ns/1ps
package etm_pkg;
  parameter int unsigned HW_W   = 16;
  parameter int unsigned N_FLAG = 4;
  // halfword indices (byte offset >> 1)
  parameter int unsigned IDX_CNT = 0;
  parameter int unsigned IDX_CMP = 4;
  parameter int unsigned IDX_MSK = 30;
  parameter int unsigned IDX_STS = 31;
  parameter int unsigned FLG_ELAPSED = 0;
endpackage

// File: rtl/etm_counter.sv
`timescale 1ns/1ps
module etm_counter #(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned HW_W  = 16,
  localparam int unsigned NHW  = CNT_W / HW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [NHW-1:0]   wr_i,
  input  logic [HW_W-1:0]  wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             chg_o
);
  logic [CNT_W-1:0] cnt_q, inc, cnt_d;
  logic             chg_q;

  assign inc = cnt_q + {{(CNT_W-1){1'b0}}, tick_i};

  for (genvar g = 0; g < NHW; g++) begin : g_hw
    // written halfword loses any tick of the same cycle
    assign cnt_d[g*HW_W +: HW_W] = wr_i[g] ? wdata_i : inc[g*HW_W +: HW_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      chg_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      chg_q <= (cnt_d != cnt_q);
    end
  end

  assign cnt_o = cnt_q;
  assign chg_o = chg_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && wr_i == '0) |=> $stable(cnt_q));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && wr_i == '0) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/etm_compare.sv
`timescale 1ns/1ps
module etm_compare #(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned HW_W  = 16,
  localparam int unsigned NHW  = CNT_W / HW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NHW-1:0]   wr_i,
  input  logic [HW_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             chg_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cmp_q;

  for (genvar g = 0; g < NHW; g++) begin : g_hw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cmp_q[g*HW_W +: HW_W] <= '0;
      else if (wr_i[g]) cmp_q[g*HW_W +: HW_W] <= wdata_i;
    end
  end

  // only evaluated on the cycle the counter has just changed
  assign hit_o = chg_i && (cnt_i == cmp_q);
  assign cmp_o = cmp_q;

  p_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i == '0) |=> $stable(cmp_q));
endmodule

// File: rtl/etm_irq.sv
`timescale 1ns/1ps
module etm_irq #(
  parameter int unsigned N_FLAG = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_FLAG-1:0] set_i,
  input  logic              wr_sts_i,
  input  logic              wr_msk_i,
  input  logic [N_FLAG-1:0] wdata_i,
  output logic [N_FLAG-1:0] sts_o,
  output logic [N_FLAG-1:0] msk_o,
  output logic              irq_o
);
  logic [N_FLAG-1:0] sts_q, msk_q, clr;

  assign clr = wr_sts_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      msk_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr) | set_i; // set wins
      if (wr_msk_i) msk_q <= wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign msk_o = msk_q;
  assign irq_o = |(sts_q & msk_q);

  p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[0] |=> sts_q[0]);
  p_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[0]) |-> $past(set_i[0]));
  p_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts_i && wdata_i[0] && !set_i[0]) |=> !sts_q[0]);
endmodule

// File: rtl/elapsed_alarm_timer.sv
`timescale 1ns/1ps
module elapsed_alarm_timer
  import etm_pkg::*;
#(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned NHW   = CNT_W / HW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [2:0]        evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [HW_W-1:0]   wdata_i,
  output logic [HW_W-1:0]   rdata_o,
  output logic              irq_o
);
  logic [ADDR_W-2:0] hw_idx;
  logic [NHW-1:0]    wr_cnt, wr_cmp;
  logic              wr_sts, wr_msk, chg, hit;
  logic [CNT_W-1:0]  cnt, cmp;
  logic [N_FLAG-1:0] sts, msk;

  assign hw_idx = addr_i[ADDR_W-1:1];

  for (genvar g = 0; g < NHW; g++) begin : g_dec
    assign wr_cnt[g] = wr_i && (hw_idx == (ADDR_W-1)'(IDX_CNT + g));
    assign wr_cmp[g] = wr_i && (hw_idx == (ADDR_W-1)'(IDX_CMP + g));
  end
  assign wr_sts = wr_i && (hw_idx == (ADDR_W-1)'(IDX_STS));
  assign wr_msk = wr_i && (hw_idx == (ADDR_W-1)'(IDX_MSK));

  etm_counter #(.CNT_W(CNT_W), .HW_W(HW_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .wr_i(wr_cnt), .wdata_i,
    .cnt_o(cnt), .chg_o(chg)
  );

  etm_compare #(.CNT_W(CNT_W), .HW_W(HW_W)) u_cmp (
    .clk_i, .rst_ni, .wr_i(wr_cmp), .wdata_i,
    .cnt_i(cnt), .chg_i(chg), .cmp_o(cmp), .hit_o(hit)
  );

  etm_irq #(.N_FLAG(N_FLAG)) u_irq (
    .clk_i, .rst_ni, .set_i({evt_i, hit}), .wr_sts_i(wr_sts),
    .wr_msk_i(wr_msk), .wdata_i(wdata_i[N_FLAG-1:0]),
    .sts_o(sts), .msk_o(msk), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NHW; g++) begin
      if (hw_idx == (ADDR_W-1)'(IDX_CNT + g)) rdata_o = cnt[g*HW_W +: HW_W];
      if (hw_idx == (ADDR_W-1)'(IDX_CMP + g)) rdata_o = cmp[g*HW_W +: HW_W];
    end
    if (hw_idx == (ADDR_W-1)'(IDX_STS)) rdata_o = {{(HW_W-N_FLAG){1'b0}}, sts};
    if (hw_idx == (ADDR_W-1)'(IDX_MSK)) rdata_o = {{(HW_W-N_FLAG){1'b0}}, msk};
  end

  p_irq_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk == '0) |-> !irq_o);
endmodule

// File: tb/sim_elapsed_alarm_timer.sv
`timescale 1ns/1ps
module sim_elapsed_alarm_timer;
  logic        clk = 0, rst_n = 0, tick = 0, wr = 0;
  logic [2:0]  evt = 0;
  logic [5:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic        irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  elapsed_alarm_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .evt_i(evt),
    .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bw(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic br(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    foreach (d[i]) ; // no-op
    br(6'h00, d); chk("R1", "cnt lo", d, 0);
    br(6'h04, d); chk("R1", "cnt hi", d, 0);
    br(6'h08, d); chk("R1", "cmp lo", d, 0);
    br(6'h3E, d); chk("R1", "status", d, 0);
    br(6'h3C, d); chk("R1", "mask", d, 0);
    chk("R1", "irq", irq, 0);
  endtask

  task automatic t_count();
    logic [15:0] d;
    ticks(5);
    br(6'h00, d); chk("R2", "after 5 ticks", d, 5);
    repeat (4) @(negedge clk);
    br(6'h00, d); chk("R2", "held", d, 5);
  endtask

  task automatic t_carry();
    logic [15:0] d;
    bw(6'h00, 16'hFFFE); bw(6'h02, 16'hFFFF); bw(6'h04, 16'h0000);
    ticks(2);
    br(6'h00, d); chk("R3", "lo wraps", d, 0);
    br(6'h02, d); chk("R3", "mid wraps", d, 0);
    br(6'h04, d); chk("R3", "hi carried", d, 1);
  endtask

  task automatic t_write_tick();
    logic [15:0] d;
    bw(6'h00, 16'hFFFF); bw(6'h02, 16'h0000); bw(6'h04, 16'h0000);
    @(negedge clk); addr = 6'h02; wdata = 16'h1234; wr = 1; tick = 1;
    @(negedge clk); wr = 0; tick = 0;
    br(6'h00, d); chk("R4", "lo ticked", d, 0);
    br(6'h02, d); chk("R4", "mid write wins", d, 16'h1234);
    br(6'h04, d); chk("R4", "hi untouched", d, 0);
  endtask

  task automatic t_seconds();
    logic [15:0] lo, mi, hi;
    // S=5 with fraction 0x7FFF
    bw(6'h00, 16'hFFFF); bw(6'h02, 16'h0002); bw(6'h04, 16'h0000);
    ticks(1);
    br(6'h00, lo); br(6'h02, mi); br(6'h04, hi);
    chk("R10", "seconds", {hi[14:0], mi, lo[15]}, 6);
    chk("R10", "fraction", {17'd0, lo[14:0]}, 0);
  endtask

  task automatic t_compare_reserved();
    logic [15:0] d;
    bw(6'h08, 16'hA5A5); bw(6'h0A, 16'h5A5A); bw(6'h0C, 16'h0F0F);
    br(6'h08, d); chk("R5", "cmp lo", d, 16'hA5A5);
    br(6'h0A, d); chk("R5", "cmp mid", d, 16'h5A5A);
    br(6'h0C, d); chk("R5", "cmp hi", d, 16'h0F0F);
    bw(6'h06, 16'hFFFF); bw(6'h0E, 16'hFFFF);
    br(6'h06, d); chk("R5", "rsvd 06", d, 0);
    br(6'h0E, d); chk("R5", "rsvd 0E", d, 0);
    br(6'h04, d); chk("R5", "cnt hi kept", d, 0);
    br(6'h0C, d); chk("R5", "cmp hi kept", d, 16'h0F0F);
  endtask

  task automatic t_alarm();
    logic [15:0] d;
    bw(6'h08, 16'h0014); bw(6'h0A, 16'h0000); bw(6'h0C, 16'h0000);
    bw(6'h00, 16'h0010); bw(6'h02, 16'h0000); bw(6'h04, 16'h0000);
    bw(6'h3C, 16'h0001);
    bw(6'h3E, 16'h000F);
    br(6'h3E, d); chk("R7", "cleared", d, 0);
    ticks(3);
    @(negedge clk);
    br(6'h3E, d); chk("R6", "no early flag", d, 0);
    chk("R9", "irq low", irq, 0);
    ticks(1);
    @(negedge clk);
    br(6'h3E, d); chk("R6", "flag on match", d, 1);
    chk("R9", "irq high", irq, 1);
    bw(6'h3E, 16'h0001);
    repeat (5) @(negedge clk);
    br(6'h3E, d); chk("R6", "no reassert held", d, 0);
    chk("R7", "irq after clear", irq, 0);
  endtask

  task automatic t_events();
    logic [15:0] d;
    bw(6'h3C, 16'h0001);
    @(negedge clk); evt = 3'b010;
    @(negedge clk); evt = 0;
    br(6'h3E, d); chk("R8", "evt1 -> bit2", d, 16'h0004);
    chk("R9", "masked off", irq, 0);
    bw(6'h3C, 16'h0004);
    br(6'h3C, d); chk("R9", "mask readback", d, 4);
    chk("R9", "unmasked", irq, 1);
    bw(6'h3E, 16'h0000);
    br(6'h3E, d); chk("R7", "zero write", d, 4);
    bw(6'h3E, 16'h000B);
    br(6'h3E, d); chk("R7", "other ones", d, 4);
    bw(6'h3E, 16'h0004);
    br(6'h3E, d); chk("R7", "cleared bit2", d, 0);
    @(negedge clk); evt = 3'b101;
    @(negedge clk); evt = 0;
    br(6'h3E, d); chk("R8", "evt0,2 -> bits1,3", d, 16'h000A);
    bw(6'h3E, 16'h000A);
    // set racing a clear
    @(negedge clk); evt = 3'b001; addr = 6'h3E; wdata = 16'h0002; wr = 1;
    @(negedge clk); evt = 0; wr = 0;
    br(6'h3E, d); chk("R7", "set wins", d, 16'h0002);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_count();
    t_carry();
    t_write_tick();
    t_seconds();
    t_compare_reserved();
    t_alarm();
    t_events();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule